// File: doc/BRIEF.md
# MMU Exception Prioritizer and Vectoring Unit

This block sits beside the translation lookaside lookup of a processor's load/store and fetch path. For each access it is offered, it takes the lookup verdict (hit or miss), the valid, permission and dirty flags of the matched entry, and a CPU address-error flag. It then decides whether the access faults, and which fault wins under a fixed priority. A CPU address error always wins. When address translation is switched on, the four translation faults follow in this order: no matching entry, matching entry not valid, access not permitted, and first write to a clean page.

For the winning fault the block produces four results. The first is an exception code, which separates the read or fetch case from the write case. The second is a handler vector formed from the vector base value; a missing entry gets a dedicated offset so that its refill handler is reached directly. The third is a saved return address, so that the faulting instruction can be re-executed. When a data access comes from an instruction in a delay slot, the saved address points at the delayed branch. The fourth is the faulting virtual address, held in a translation-exception address register.

Accesses arrive as a qualified valid strobe with no back-pressure, one per clock at most. Results appear one clock later together with a one-cycle request pulse. The block cannot stall its producer, so it has no ready signal.

Top module: `mmux_exc_top`

## Requirements
- R1: An access with `addr_err` high raises a request whatever the translation inputs are. Its code is 0x0E0 for a fetch or read and 0x100 for a write, and its vector is `vbr` + 0x100. `fault_va` is left unchanged.
- R2: With `addr_err` low and `xlat_en` low, an access raises no request.
- R3: With translation on and `tlb_hit` low, the code is 0x040 for a fetch or read and 0x060 for a write. The vector is `vbr` + 0x400.
- R4: With a hit on an entry whose `ent_valid` is low, the code is 0x040 for a fetch or read and 0x060 for a write. The vector is `vbr` + 0x100.
- R5: With a hit on a valid entry whose `ent_perm_ok` is low, the code is 0x0A0 for a fetch or read and 0x0C0 for a write. The vector is `vbr` + 0x100.
- R6: A write that hits a valid, permitted entry whose `ent_dirty` is low gives code 0x080 with vector `vbr` + 0x100. A fetch or read to the same entry does not fault.
- R7: An access with no fault raises no request. `exc_req` is high for exactly the one cycle that follows each faulting access, and it is never high after a cycle without `acc_valid`.
- R8: On every translation fault (R3 to R6), `fault_va` takes the access's full virtual address one cycle later. At all other times it keeps its value.
- R9: The saved address `exc_ret` is `acc_va` for a fetch. For a read or write it is `cur_pc`, or `br_pc` when `in_dslot` is high.
- R10: `acc_kind` encodes 0 as fetch, 1 as read and 2 as write; 3 is treated as a read. Under reset `exc_req` is low and `fault_va` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access offered this cycle |
| acc_kind | input | 2 | 0 fetch, 1 read, 2 write, 3 read |
| acc_va | input | VA_W | Virtual address of the access |
| addr_err | input | 1 | CPU address error detected for this access |
| xlat_en | input | 1 | Address translation switched on |
| tlb_hit | input | 1 | Some entry matched the address |
| ent_valid | input | 1 | Matched entry is valid |
| ent_perm_ok | input | 1 | Matched entry permits this access |
| ent_dirty | input | 1 | Matched entry already written |
| cur_pc | input | VA_W | Address of the instruction making the access |
| in_dslot | input | 1 | That instruction sits in a delay slot |
| br_pc | input | VA_W | Address of the delayed branch owning the slot |
| vbr | input | VA_W | Vector base value |
| exc_req | output | 1 | One-cycle exception request |
| exc_code | output | 12 | Exception code of the winning fault |
| exc_vec | output | VA_W | Handler vector address |
| exc_ret | output | VA_W | Saved return address |
| fault_va | output | VA_W | Translation-exception address register |

## Verification
The bench builds the block with its defaults: a 32-bit address width, a miss offset of 0x400 and a shared offset of 0x100. At these settings the codes, vectors and captured addresses can be compared against the numbers in the requirements. Directed cycles place each fault class alone and stacked under a higher one, and address each `acc_kind` value, including the reserved one. They also cover the delay-slot redirection and back-to-back faulting cycles. Random cycles biased toward hits then mix the classes against a behavioural model, so that `fault_va` holding across address errors and clean accesses is checked on every clock.

// File: rtl/mmux_pkg.sv
package mmux_pkg;

  localparam int CODE_W = 12;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_ALT   = 2'd3
  } acc_kind_e;

  typedef enum logic [2:0] {
    FLT_NONE    = 3'd0,
    FLT_ADDR    = 3'd1,
    FLT_MISS    = 3'd2,
    FLT_INVALID = 3'd3,
    FLT_PROT    = 3'd4,
    FLT_IPW     = 3'd5
  } fault_e;

  localparam int NUM_CLS = 5;

  localparam logic [CODE_W-1:0] CODE_AERR_RD = 12'h0E0;
  localparam logic [CODE_W-1:0] CODE_AERR_WR = 12'h100;
  localparam logic [CODE_W-1:0] CODE_MISS_RD = 12'h040;
  localparam logic [CODE_W-1:0] CODE_MISS_WR = 12'h060;
  localparam logic [CODE_W-1:0] CODE_PROT_RD = 12'h0A0;
  localparam logic [CODE_W-1:0] CODE_PROT_WR = 12'h0C0;
  localparam logic [CODE_W-1:0] CODE_IPW     = 12'h080;

  function automatic logic is_store(input logic [1:0] kind);
    return kind == ACC_WRITE;
  endfunction

  function automatic logic is_xlat_fault(input fault_e f);
    return (f == FLT_MISS) || (f == FLT_INVALID) ||
           (f == FLT_PROT) || (f == FLT_IPW);
  endfunction

endpackage

// File: rtl/mmux_classify.sv
module mmux_classify
  import mmux_pkg::*;
(
  input  logic       acc_valid,
  input  logic [1:0] acc_kind,
  input  logic       addr_err,
  input  logic       xlat_en,
  input  logic       tlb_hit,
  input  logic       ent_valid,
  input  logic       ent_perm_ok,
  input  logic       ent_dirty,
  output fault_e     fault
);

  // Candidate conditions, index = priority (0 highest)
  logic [NUM_CLS-1:0] cand;
  fault_e             cls_of [NUM_CLS];

  assign cls_of[0] = FLT_ADDR;
  assign cls_of[1] = FLT_MISS;
  assign cls_of[2] = FLT_INVALID;
  assign cls_of[3] = FLT_PROT;
  assign cls_of[4] = FLT_IPW;

  logic xl;
  assign xl = acc_valid && xlat_en;

  assign cand[0] = acc_valid && addr_err;
  assign cand[1] = xl && !tlb_hit;
  assign cand[2] = xl && tlb_hit && !ent_valid;
  assign cand[3] = xl && tlb_hit && ent_valid && !ent_perm_ok;
  assign cand[4] = xl && tlb_hit && ent_valid && ent_perm_ok &&
                   is_store(acc_kind) && !ent_dirty;

  // Mask of lower classes blocked by a higher one
  logic [NUM_CLS-1:0] win;
  genvar gi;
  generate
    for (gi = 0; gi < NUM_CLS; gi++) begin : g_pri
      if (gi == 0) begin : g_top
        assign win[gi] = cand[gi];
      end else begin : g_rest
        assign win[gi] = cand[gi] && !(|cand[gi-1:0]);
      end
    end
  endgenerate

  always_comb begin
    fault = FLT_NONE;
    for (int i = 0; i < NUM_CLS; i++) begin
      if (win[i]) fault = cls_of[i];
    end
  end

endmodule

// File: rtl/mmux_vector.sv
module mmux_vector
  import mmux_pkg::*;
#(
  parameter int          VA_W     = 32,
  parameter int unsigned MISS_OFS = 32'h400,
  parameter int unsigned GEN_OFS  = 32'h100
) (
  input  fault_e            fault,
  input  logic [1:0]        acc_kind,
  input  logic [VA_W-1:0]   vbr,
  output logic [CODE_W-1:0] code,
  output logic [VA_W-1:0]   vec
);

  localparam logic [VA_W-1:0] MISS_V = VA_W'(MISS_OFS);
  localparam logic [VA_W-1:0] GEN_V  = VA_W'(GEN_OFS);

  logic wr;
  assign wr = is_store(acc_kind);

  always_comb begin
    unique case (fault)
      FLT_ADDR:    code = wr ? CODE_AERR_WR : CODE_AERR_RD;
      FLT_MISS,
      FLT_INVALID: code = wr ? CODE_MISS_WR : CODE_MISS_RD;
      FLT_PROT:    code = wr ? CODE_PROT_WR : CODE_PROT_RD;
      FLT_IPW:     code = CODE_IPW;
      default:     code = '0;
    endcase
  end

  assign vec = vbr + ((fault == FLT_MISS) ? MISS_V : GEN_V);

endmodule

// File: rtl/mmux_retaddr.sv
module mmux_retaddr
  import mmux_pkg::*;
#(
  parameter int VA_W = 32
) (
  input  logic [1:0]      acc_kind,
  input  logic [VA_W-1:0] acc_va,
  input  logic [VA_W-1:0] cur_pc,
  input  logic            in_dslot,
  input  logic [VA_W-1:0] br_pc,
  output logic [VA_W-1:0] ret
);

  logic [VA_W-1:0] data_ret;
  assign data_ret = in_dslot ? br_pc : cur_pc;
  assign ret      = (acc_kind == ACC_FETCH) ? acc_va : data_ret;

endmodule

// File: rtl/mmux_capture.sv
module mmux_capture
  import mmux_pkg::*;
#(
  parameter int VA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fault_e            fault,
  input  logic [CODE_W-1:0] code_d,
  input  logic [VA_W-1:0]   vec_d,
  input  logic [VA_W-1:0]   ret_d,
  input  logic [VA_W-1:0]   va_d,
  output logic              req_q,
  output logic [CODE_W-1:0] code_q,
  output logic [VA_W-1:0]   vec_q,
  output logic [VA_W-1:0]   ret_q,
  output logic [VA_W-1:0]   tea_q
);

  logic taken;
  assign taken = fault != FLT_NONE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      code_q <= '0;
      vec_q  <= '0;
      ret_q  <= '0;
      tea_q  <= '0;
    end else begin
      req_q <= taken;
      if (taken) begin
        code_q <= code_d;
        vec_q  <= vec_d;
        ret_q  <= ret_d;
      end
      if (is_xlat_fault(fault)) tea_q <= va_d;
    end
  end

endmodule

// File: rtl/mmux_exc_top.sv
module mmux_exc_top
  import mmux_pkg::*;
#(
  parameter int          VA_W     = 32,
  parameter int unsigned MISS_OFS = 32'h400,
  parameter int unsigned GEN_OFS  = 32'h100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [1:0]        acc_kind,
  input  logic [VA_W-1:0]   acc_va,
  input  logic              addr_err,
  input  logic              xlat_en,
  input  logic              tlb_hit,
  input  logic              ent_valid,
  input  logic              ent_perm_ok,
  input  logic              ent_dirty,
  input  logic [VA_W-1:0]   cur_pc,
  input  logic              in_dslot,
  input  logic [VA_W-1:0]   br_pc,
  input  logic [VA_W-1:0]   vbr,
  output logic              exc_req,
  output logic [CODE_W-1:0] exc_code,
  output logic [VA_W-1:0]   exc_vec,
  output logic [VA_W-1:0]   exc_ret,
  output logic [VA_W-1:0]   fault_va
);

  fault_e            fault;
  logic [CODE_W-1:0] code_d;
  logic [VA_W-1:0]   vec_d;
  logic [VA_W-1:0]   ret_d;

  mmux_classify u_cls (
    .acc_valid   (acc_valid),
    .acc_kind    (acc_kind),
    .addr_err    (addr_err),
    .xlat_en     (xlat_en),
    .tlb_hit     (tlb_hit),
    .ent_valid   (ent_valid),
    .ent_perm_ok (ent_perm_ok),
    .ent_dirty   (ent_dirty),
    .fault       (fault)
  );

  mmux_vector #(.VA_W(VA_W), .MISS_OFS(MISS_OFS), .GEN_OFS(GEN_OFS)) u_vec (
    .fault    (fault),
    .acc_kind (acc_kind),
    .vbr      (vbr),
    .code     (code_d),
    .vec      (vec_d)
  );

  mmux_retaddr #(.VA_W(VA_W)) u_ret (
    .acc_kind (acc_kind),
    .acc_va   (acc_va),
    .cur_pc   (cur_pc),
    .in_dslot (in_dslot),
    .br_pc    (br_pc),
    .ret      (ret_d)
  );

  mmux_capture #(.VA_W(VA_W)) u_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .fault  (fault),
    .code_d (code_d),
    .vec_d  (vec_d),
    .ret_d  (ret_d),
    .va_d   (acc_va),
    .req_q  (exc_req),
    .code_q (exc_code),
    .vec_q  (exc_vec),
    .ret_q  (exc_ret),
    .tea_q  (fault_va)
  );

endmodule

// File: rtl/mmux_exc_chk.sv
module mmux_exc_chk
  import mmux_pkg::*;
#(
  parameter int VA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic [1:0]        acc_kind,
  input logic [VA_W-1:0]   acc_va,
  input logic              addr_err,
  input logic              xlat_en,
  input logic              tlb_hit,
  input logic              ent_valid,
  input logic              ent_perm_ok,
  input logic              ent_dirty,
  input logic [VA_W-1:0]   br_pc,
  input logic              in_dslot,
  input logic [VA_W-1:0]   vbr,
  input logic              exc_req,
  input logic [CODE_W-1:0] exc_code,
  input logic [VA_W-1:0]   exc_vec,
  input logic [VA_W-1:0]   exc_ret,
  input logic [VA_W-1:0]   fault_va
);

  logic past_ok;
  always_ff @(posedge clk) past_ok <= rst_n;

  // R7
  req_needs_access_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    exc_req |-> $past(acc_valid));

  // R1
  aerr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    $past(acc_valid && addr_err) |->
      exc_req && (exc_code == CODE_AERR_RD || exc_code == CODE_AERR_WR) &&
      $stable(fault_va));

  // R3
  miss_vector_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    $past(acc_valid && !addr_err && xlat_en && !tlb_hit) |->
      exc_req && exc_vec == $past(vbr) + VA_W'(32'h400));

  // R2
  xlat_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    $past(acc_valid && !addr_err && !xlat_en) |-> !exc_req);

  // R6
  read_clean_page_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    $past(acc_valid && !addr_err && xlat_en && tlb_hit && ent_valid &&
          ent_perm_ok && acc_kind != 2'd2) |-> !exc_req);

  // R8
  tea_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    !exc_req |-> $stable(fault_va));

  // R8
  tea_load_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    $past(acc_valid && !addr_err && xlat_en && !tlb_hit) |-> fault_va == $past(acc_va));

  // R9
  dslot_ret_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    $past(acc_valid && addr_err && acc_kind != 2'd0 && in_dslot) |->
      exc_ret == $past(br_pc));

endmodule

bind mmux_exc_top mmux_exc_chk #(.VA_W(VA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .acc_valid   (acc_valid),
  .acc_kind    (acc_kind),
  .acc_va      (acc_va),
  .addr_err    (addr_err),
  .xlat_en     (xlat_en),
  .tlb_hit     (tlb_hit),
  .ent_valid   (ent_valid),
  .ent_perm_ok (ent_perm_ok),
  .ent_dirty   (ent_dirty),
  .br_pc       (br_pc),
  .in_dslot    (in_dslot),
  .vbr         (vbr),
  .exc_req     (exc_req),
  .exc_code    (exc_code),
  .exc_vec     (exc_vec),
  .exc_ret     (exc_ret),
  .fault_va    (fault_va)
);

// File: tb/sim_mmux_exc_top.sv
module sim_mmux_exc_top;

  localparam int CLK_PERIOD = 10;
  localparam int VA_W       = 32;
  localparam int WATCHDOG   = 50000;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            acc_valid = 1'b0;
  logic [1:0]      acc_kind = 2'd0;
  logic [VA_W-1:0] acc_va = '0;
  logic            addr_err = 1'b0;
  logic            xlat_en = 1'b0;
  logic            tlb_hit = 1'b0;
  logic            ent_valid = 1'b0;
  logic            ent_perm_ok = 1'b0;
  logic            ent_dirty = 1'b0;
  logic [VA_W-1:0] cur_pc = '0;
  logic            in_dslot = 1'b0;
  logic [VA_W-1:0] br_pc = '0;
  logic [VA_W-1:0] vbr = '0;
  logic            exc_req;
  logic [11:0]     exc_code;
  logic [VA_W-1:0] exc_vec;
  logic [VA_W-1:0] exc_ret;
  logic [VA_W-1:0] fault_va;

  mmux_exc_top u0 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_kind(acc_kind),
    .acc_va(acc_va), .addr_err(addr_err), .xlat_en(xlat_en), .tlb_hit(tlb_hit),
    .ent_valid(ent_valid), .ent_perm_ok(ent_perm_ok), .ent_dirty(ent_dirty),
    .cur_pc(cur_pc), .in_dslot(in_dslot), .br_pc(br_pc), .vbr(vbr),
    .exc_req(exc_req), .exc_code(exc_code), .exc_vec(exc_vec),
    .exc_ret(exc_ret), .fault_va(fault_va)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  // model state
  bit              m_req;
  logic [11:0]     m_code;
  logic [VA_W-1:0] m_vec, m_ret, m_tea;
  string           m_tag;

  task automatic check(input string tag, input string what,
                       input logic [VA_W-1:0] act, input logic [VA_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // Behavioural model of the requirements for the inputs now applied
  task automatic predict();
    bit wr;
    wr = (acc_kind == 2'd2);
    m_req = 1; m_tag = "R7";
    if (!acc_valid) begin
      m_req = 0; m_tag = "R7";
    end else if (addr_err) begin
      m_tag = "R1"; m_code = wr ? 12'h100 : 12'h0E0; m_vec = vbr + 32'h100;
    end else if (!xlat_en) begin
      m_req = 0; m_tag = "R2";
    end else if (!tlb_hit) begin
      m_tag = "R3"; m_code = wr ? 12'h060 : 12'h040; m_vec = vbr + 32'h400;
    end else if (!ent_valid) begin
      m_tag = "R4"; m_code = wr ? 12'h060 : 12'h040; m_vec = vbr + 32'h100;
    end else if (!ent_perm_ok) begin
      m_tag = "R5"; m_code = wr ? 12'h0C0 : 12'h0A0; m_vec = vbr + 32'h100;
    end else if (wr && !ent_dirty) begin
      m_tag = "R6"; m_code = 12'h080; m_vec = vbr + 32'h100;
    end else begin
      m_req = 0; m_tag = (!ent_dirty) ? "R6" : "R7";
    end
    if (m_req) begin
      m_ret = (acc_kind == 2'd0) ? acc_va : (in_dslot ? br_pc : cur_pc);
      if (m_tag != "R1") m_tea = acc_va;
    end
  endtask

  // Compare outputs (called at negedge, one cycle after the inputs)
  task automatic compare();
    check(m_tag, "exc_req", VA_W'(exc_req), VA_W'(m_req));
    if (m_req && exc_req) begin
      check(m_tag, "exc_code", VA_W'(exc_code), VA_W'(m_code));
      check(m_tag, "exc_vec", exc_vec, m_vec);
      check("R9", "exc_ret", exc_ret, m_ret);
    end
    check("R8", "fault_va", fault_va, m_tea);
  endtask

  task automatic drive(input bit v, input logic [1:0] k, input logic [31:0] va,
                       input bit ae, input bit xe, input bit h, input bit ev,
                       input bit pk, input bit dt, input bit ds);
    @(negedge clk);
    compare();
    acc_valid = v; acc_kind = k; acc_va = va; addr_err = ae; xlat_en = xe;
    tlb_hit = h; ent_valid = ev; ent_perm_ok = pk; ent_dirty = dt; in_dslot = ds;
    cur_pc = $urandom; br_pc = $urandom; vbr = {$urandom} & 32'hFFFF_FC00;
    predict();
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > WATCHDOG) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog expired after %0d cycles", cyc);
        finish_run();
      end
    end
  end

  initial begin
    m_req = 0; m_tea = '0; m_tag = "R10";
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    check("R10", "exc_req", VA_W'(exc_req), '0);
    check("R10", "fault_va", fault_va, '0);
    rst_n = 1'b1;
    predict();
    // R1: address error over every translation outcome, all kinds
    drive(1, 2'd1, 32'hA000_0001, 1, 1, 0, 0, 0, 0, 0);
    drive(1, 2'd2, 32'hA000_0002, 1, 1, 1, 1, 0, 0, 1);
    drive(1, 2'd0, 32'hA000_0003, 1, 0, 1, 1, 1, 1, 0);
    // R2: translation off
    drive(1, 2'd2, 32'hB000_0000, 0, 0, 0, 0, 0, 0, 0);
    // R3: miss, read / write / fetch / reserved kind (R10)
    drive(1, 2'd1, 32'h1234_5678, 0, 1, 0, 1, 1, 1, 0);
    drive(1, 2'd2, 32'h1234_567C, 0, 1, 0, 0, 0, 0, 1);
    drive(1, 2'd0, 32'h0000_4000, 0, 1, 0, 0, 0, 0, 1);
    drive(1, 2'd3, 32'h0000_5000, 0, 1, 0, 0, 0, 0, 0);
    // R4: invalid entry
    drive(1, 2'd1, 32'h2000_0010, 0, 1, 1, 0, 0, 0, 1);
    drive(1, 2'd2, 32'h2000_0020, 0, 1, 1, 0, 1, 0, 0);
    // R5: protection
    drive(1, 2'd0, 32'h3000_0010, 0, 1, 1, 1, 0, 0, 0);
    drive(1, 2'd2, 32'h3000_0020, 0, 1, 1, 1, 0, 0, 1);
    // R6: initial page write, and read to clean page does not fault
    drive(1, 2'd2, 32'h4000_0040, 0, 1, 1, 1, 1, 0, 1);
    drive(1, 2'd1, 32'h4000_0044, 0, 1, 1, 1, 1, 0, 0);
    // R7: clean write, idle cycle with faulting-looking inputs
    drive(1, 2'd2, 32'h5000_0000, 0, 1, 1, 1, 1, 1, 0);
    drive(0, 2'd1, 32'h5000_0004, 1, 1, 0, 0, 0, 0, 0);
    drive(0, 2'd1, 32'h5000_0008, 0, 0, 0, 0, 0, 0, 0);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      drive(($urandom % 8) != 0, 2'($urandom), $urandom,
            ($urandom % 6) == 0, ($urandom % 5) != 0, ($urandom % 4) != 0,
            ($urandom % 4) != 0, ($urandom % 4) != 0, ($urandom % 2) != 0,
            ($urandom % 2) != 0);
    end
    drive(0, 2'd0, 32'h0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    compare();
    finish_run();
  end

endmodule